// File: doc/BRIEF.md
# Processor Power-Up Sequencer

This block moves a processor between deep sleep and active operation using external power-gate switches. In sleep, the cluster and clock-generator regions are switched off. The always-on system region keeps its supply, so memory contents survive sleep and no reload is needed at wake-up. A wake-up pulse from the sensor readout controller starts a sequence with four states:

- `ST_IDLE`: everything off.
- `ST_POWER_UP`: one gate request drives both switched regions. The block waits here for the switches to report power good.
- `ST_RUN`: fetch-enable is high and the processor runs.
- `ST_POWER_DOWN`: the request is withdrawn. The block waits for the acknowledge to fall before returning to `ST_IDLE`.

The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_POWER_UP` | wake-up pulse, or a latched pending wake-up |
| `ST_POWER_UP` | `ST_RUN` | acknowledge high |
| `ST_POWER_UP` | `ST_POWER_DOWN` | acknowledge absent for the whole power-up window |
| `ST_RUN` | `ST_POWER_DOWN` | end-of-computation from the processor |
| `ST_POWER_DOWN` | `ST_IDLE` | acknowledge low |

Power-on plus clock lock takes roughly 590 µs, and boot takes roughly 61 µs more. The power-up window `TIMEOUT_CYCLES` should therefore cover at least 590 µs of the sequencer clock. If the window expires, the block raises an error flag and powers down. Wake-up pulses that arrive while the block is busy are collapsed into one pending request, which is serviced after the return to idle.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset, `pg_req_o`, `fetch_en_o`, `busy_o` and `pwr_err_o` are all 0 and the state is `ST_IDLE`.
- R2: A wake-up pulse sampled in `ST_IDLE` raises `pg_req_o` and `busy_o` on the following clock edge. That single request powers both switched regions.
- R3: `fetch_en_o` rises only on the edge after `pg_ack_i` is sampled high in `ST_POWER_UP`. It is 1 only while `pg_req_o` is 1.
- R4: `eoc_i` sampled high in `ST_RUN` clears both `fetch_en_o` and `pg_req_o` on the next edge.
- R5: In `ST_POWER_DOWN`, `busy_o` stays 1 while `pg_ack_i` is 1. The block re-enters `ST_IDLE` (`busy_o` = 0) on the first edge at which `pg_ack_i` is sampled low.
- R6: If `pg_ack_i` stays low for `TIMEOUT_CYCLES` consecutive edges in `ST_POWER_UP`:
  - `pwr_err_o` becomes 1 on the last of those edges;
  - `pg_req_o` drops on that same edge;
  - `fetch_en_o` is never raised.
- R7: `pwr_err_o` holds through idle and clears on the edge that starts the next activation.
- R8: Any number of wake-up pulses seen while `busy_o` is 1 cause exactly one extra activation. That activation starts on the edge after the block returns to `ST_IDLE`.
- R9: `eoc_i` and `pg_ack_i` have no effect in `ST_IDLE`: without a wake-up, `busy_o` and `pg_req_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Wake-up pulse from the readout controller |
| pg_ack_i | input | 1 | Power-good acknowledge from the gate switches |
| eoc_i | input | 1 | End-of-computation from the processor |
| pg_req_o | output | 1 | Power-on request to the cluster and clock-generator gates |
| fetch_en_o | output | 1 | Lets the processor start fetching instructions |
| busy_o | output | 1 | High whenever the sequencer is outside idle |
| pwr_err_o | output | 1 | Power-up acknowledge timed out during the last activation |

## Verification
All outputs decode the registered state, so a wrong state shows at the ports on the very next edge:

- A missed transition leaves `pg_req_o` or `fetch_en_o` at the wrong level one cycle after the triggering input.
- A lost pending wake-up appears as `busy_o` staying low on the cycle after the return to idle.
- An off-by-one in the timeout counter moves the rise of `pwr_err_o` one cycle from edge `TIMEOUT_CYCLES`.

A cycle-by-cycle reference model in the bench compares all four outputs every cycle. Random acknowledge and end-of-computation traffic then exposes such faults within a few activations.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_POWER_UP   = 2'd1,
        ST_RUN        = 2'd2,
        ST_POWER_DOWN = 2'd3
    } pseq_state_e;

endpackage

// File: rtl/pseq_wake_latch.sv
module pseq_wake_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wake_i,
    input  logic idle_i,
    input  logic start_i,
    output logic pend_o
);

    logic pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b0;
        end else if (wake_i && !idle_i) begin
            pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

    AST_WAKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_i && !idle_i) |=> pend_o); // R8
    AST_PEND_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !pend_o); // R8

endmodule

// File: rtl/pseq_timeout.sv
module pseq_timeout #(
    parameter int unsigned TIMEOUT_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = en_i && (cnt_q == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST); // R6
    AST_CNT_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
    import pseq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wake_i,
    input  logic        pend_i,
    input  logic        ack_i,
    input  logic        eoc_i,
    input  logic        expire_i,
    output pseq_state_e state_o,
    output logic        start_o,
    output logic        pg_req_o,
    output logic        fetch_en_o,
    output logic        busy_o,
    output logic        err_o
);

    pseq_state_e state_q, state_d;
    logic        err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (wake_i || pend_i) state_d = ST_POWER_UP;
            ST_POWER_UP:   if (ack_i)            state_d = ST_RUN;
                           else if (expire_i)    state_d = ST_POWER_DOWN;
            ST_RUN:        if (eoc_i)            state_d = ST_POWER_DOWN;
            ST_POWER_DOWN: if (!ack_i)           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_POWER_UP) begin
                err_q <= 1'b0;
            end else if (state_q == ST_POWER_UP && !ack_i && expire_i) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        pg_req_o   = 1'b0;
        fetch_en_o = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE:       busy_o = 1'b0;
            ST_POWER_UP:   pg_req_o = 1'b1;
            ST_RUN: begin
                pg_req_o   = 1'b1;
                fetch_en_o = 1'b1;
            end
            ST_POWER_DOWN: ;
        endcase
    end

    assign start_o = (state_q == ST_IDLE) && (wake_i || pend_i);
    assign err_o   = err_q;
    assign state_o = state_q;

    AST_WAKE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && wake_i) |=> (pg_req_o && busy_o)); // R2
    AST_FETCH_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fetch_en_o) |-> $past(ack_i)); // R3
    AST_EOC_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_en_o && eoc_i) |=> (!fetch_en_o && !pg_req_o)); // R4
    AST_IDLE_ACK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> !$past(ack_i)); // R5
    AST_ERR_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> (!pg_req_o && !fetch_en_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !wake_i && !pend_i) |=> !busy_o); // R9

endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
    import pseq_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wake_i,
    input  logic pg_ack_i,
    input  logic eoc_i,
    output logic pg_req_o,
    output logic fetch_en_o,
    output logic busy_o,
    output logic pwr_err_o
);

    pseq_state_e state;
    logic        pend;
    logic        start;
    logic        expire;
    logic        in_power_up;
    logic        busy;

    assign in_power_up = (state == ST_POWER_UP);
    assign busy_o      = busy;

    pseq_wake_latch i_wake_latch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wake_i  (wake_i),
        .idle_i  (!busy),
        .start_i (start),
        .pend_o  (pend)
    );

    pseq_timeout #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) i_timeout (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (in_power_up),
        .expire_o (expire)
    );

    pseq_fsm i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wake_i     (wake_i),
        .pend_i     (pend),
        .ack_i      (pg_ack_i),
        .eoc_i      (eoc_i),
        .expire_i   (expire),
        .state_o    (state),
        .start_o    (start),
        .pg_req_o   (pg_req_o),
        .fetch_en_o (fetch_en_o),
        .busy_o     (busy),
        .err_o      (pwr_err_o)
    );

    AST_FETCH_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_en_o |-> pg_req_o); // R3
    AST_ERR_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_err_o && !busy && !wake_i && !pend) |=> pwr_err_o); // R7

endmodule

// File: tb/test_pwr_sequencer.sv
module test_pwr_sequencer;

    localparam int TO = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 1'b0, ack = 1'b0, eoc = 1'b0;
    logic pg_req, fetch_en, busy, pwr_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_sequencer #(.TIMEOUT_CYCLES(TO)) i_pwr_sequencer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wake_i     (wake),
        .pg_ack_i   (ack),
        .eoc_i      (eoc),
        .pg_req_o   (pg_req),
        .fetch_en_o (fetch_en),
        .busy_o     (busy),
        .pwr_err_o  (pwr_err)
    );

    // reference model: 0 idle, 1 power-up, 2 run, 3 power-down
    int m_st = 0, m_cnt = 0;
    bit m_pend = 0, m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_pend <= 0; m_err <= 0;
        end else begin
            case (m_st)
                0: if (wake || m_pend) begin
                       m_st <= 1; m_cnt <= 0; m_err <= 0; m_pend <= 0;
                   end
                1: begin
                       if (wake) m_pend <= 1;
                       if (ack) m_st <= 2;
                       else if (m_cnt == TO - 1) begin m_st <= 3; m_err <= 1; end
                       else m_cnt <= m_cnt + 1;
                   end
                2: begin if (wake) m_pend <= 1; if (eoc) m_st <= 3; end
                default: begin if (wake) m_pend <= 1; if (!ack) m_st <= 0; end
            endcase
        end
    end

    function automatic bit exp_req(int st);   return st == 1 || st == 2; endfunction
    function automatic bit exp_fetch(int st); return st == 2;            endfunction
    function automatic bit exp_busy(int st);  return st != 0;            endfunction

    task automatic chk(input logic act, input logic expv, input string tag);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic cmp_all();
        chk(pg_req,   exp_req(m_st),   "R2 pg_req model");
        chk(fetch_en, exp_fetch(m_st), "R3 fetch_en model");
        chk(busy,     exp_busy(m_st),  "R5 busy model");
        chk(pwr_err,  m_err,           "R6 err model");
    endtask

    task automatic step(input logic w, input logic a, input logic e);
        wake = w; ack = a; eoc = e;
        @(negedge clk);
        cmp_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pg_req, 1'b0, "R1 pg_req"); chk(fetch_en, 1'b0, "R1 fetch_en");
        chk(busy, 1'b0, "R1 busy");     chk(pwr_err, 1'b0, "R1 err");

        // normal activation
        step(1, 0, 0);
        chk(pg_req, 1'b1, "R2 req after wake"); chk(busy, 1'b1, "R2 busy after wake");
        step(0, 0, 0); step(0, 0, 0);
        chk(fetch_en, 1'b0, "R3 no fetch before ack");
        step(0, 1, 0);
        chk(fetch_en, 1'b1, "R3 fetch after ack");
        step(0, 1, 0); step(0, 1, 0);
        step(0, 1, 1);
        chk(fetch_en, 1'b0, "R4 fetch dropped"); chk(pg_req, 1'b0, "R4 req dropped");
        step(0, 1, 0); step(0, 1, 0);
        chk(busy, 1'b1, "R5 busy while ack high");
        step(0, 0, 0);
        chk(busy, 1'b0, "R5 idle after ack low");

        // timeout
        step(1, 0, 0);
        for (int i = 0; i < TO - 1; i++) step(0, 0, 0);
        chk(pwr_err, 1'b0, "R6 no err one cycle early"); chk(pg_req, 1'b1, "R6 req held");
        step(0, 0, 0);
        chk(pwr_err, 1'b1, "R6 err on expiry"); chk(pg_req, 1'b0, "R6 req dropped");
        chk(fetch_en, 1'b0, "R6 no fetch");
        step(0, 0, 0); step(0, 0, 0);
        chk(busy, 1'b0, "R7 idle after timeout"); chk(pwr_err, 1'b1, "R7 err held");
        step(1, 0, 0);
        chk(pwr_err, 1'b0, "R7 err cleared at start");
        step(0, 1, 0); step(0, 1, 0);

        // R8 wakes while busy collapse into one
        step(1, 1, 0); step(1, 1, 0);
        step(0, 1, 1); step(1, 1, 0); step(0, 0, 0);
        chk(busy, 1'b0, "R8 idle one cycle");
        step(0, 0, 0);
        chk(busy, 1'b1, "R8 pending serviced"); chk(pg_req, 1'b1, "R8 req for pending");
        step(0, 1, 0); step(0, 1, 1); step(0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0);
            chk(busy, 1'b0, "R8 serviced only once");
        end

        // R9 stray inputs in idle
        step(0, 0, 1); step(0, 1, 0); step(0, 1, 1);
        chk(busy, 1'b0, "R9 busy stays low"); chk(pg_req, 1'b0, "R9 req stays low");
        step(0, 0, 0);

        // constrained random traffic
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) == 0, ($urandom % 3) != 0, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule